// File: doc/BRIEF.md
# Bus Hold and Ready Controller

This block decides who owns a small processor's external bus. An outside master asks for the bus by pulling an active-low hold request low. The block acknowledges on an active-low output. It then stops driving the address, multiplexed address/data, read/write and byte-high-enable pads. It also makes the internal clock phase that paces bus cycles, and an active-low ready input can freeze that phase to stretch an access to slow memory.

A separate free-running clock is made for an output pin, and ready never stalls it. A disable control can replace that clock with a stored port latch value. The latch only reaches the pin when the port's direction bit selects output. The pads are outside the block: it provides one shared output-enable for the bus pads, plus a value and an enable for the clock pin.

A request is passed through a synchronizer. It is acted on only when the internal phase goes from high to low and no bus cycle is running. The bus pads change state one full internal clock cycle after the acknowledge changes, in both directions.

Top module: `bus_hold_ready_ctrl`

## Requirements
- R1: While `rst_n` is low, `hlda_n_o` is 1, `bus_oe_o` is 1, `bus_go_o` is 1 and `phi_o` is 0.
- R2: `phi_o` inverts on each rising `clk` edge where `ce_i` is 1 and it is not frozen (see R3). It keeps its value on edges where `ce_i` is 0.
- R3: While `rdy_n_i` is 0 and `phi_o` is 0, `phi_o` stays 0. It toggles again once `rdy_n_i` returns to 1.
- R4: The free clock inverts on every enabled edge whether or not `rdy_n_i` is 0. It is seen on `clkpin_o` when `out_dis_i` is 0.
- R5: When `out_dis_i` is 0, `clkpin_oe_o` is 1. When `out_dis_i` is 1, `clkpin_o` equals `port_latch_i` and `clkpin_oe_o` equals `port_dir_i`.
- R6: A low `hold_req_n_i` is seen after `SYNC_STAGES` flops. `hlda_n_o` goes to 0 only on an edge where `phi_o` falls from 1 to 0.
- R7: While `bus_busy_i` is 1, a pending request is not acknowledged. It is acknowledged at a falling phase after `bus_busy_i` returns to 0.
- R8: `bus_oe_o` goes to 0 one internal clock cycle after `hlda_n_o` goes to 0. This is two `clk` cycles when `ce_i` is always 1, and four when `ce_i` is high every other cycle.
- R9: After the request is removed, `hlda_n_o` returns to 1 on a falling phase. `bus_oe_o` returns to 1 one internal clock cycle later.
- R10: `bus_go_o` is 1 only when `hlda_n_o` and `bus_oe_o` are both 1. The core may start bus cycles only then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_i | input | 1 | Internal clock enable from the oscillator divider |
| rdy_n_i | input | 1 | Active-low ready; low stretches the access |
| hold_req_n_i | input | 1 | Active-low bus hold request, asynchronous |
| bus_busy_i | input | 1 | High while the core has a bus cycle in progress |
| out_dis_i | input | 1 | Clock pin output disable control |
| port_dir_i | input | 1 | Direction bit of the port sharing the clock pin (1 = output) |
| port_latch_i | input | 1 | Latched port value for the clock pin |
| phi_o | output | 1 | Internal clock phase |
| hlda_n_o | output | 1 | Active-low hold acknowledge |
| bus_oe_o | output | 1 | Output enable for address, data, read/write and byte-high pads |
| bus_go_o | output | 1 | Core may run bus cycles |
| clkpin_o | output | 1 | Clock pin value |
| clkpin_oe_o | output | 1 | Clock pin output enable |

## Verification
The assertions assume that `bus_busy_i` and `rdy_n_i` are already in the master clock domain. Only `hold_req_n_i` is asynchronous. They also assume `ce_i` is a plain enable with no glitches. The stimulus changes every input at the falling edge of `clk`, away from the sampling edge. It runs `ce_i` either held at 1 or toggling every cycle, so the internal cycle length of R8 and R9 is known exactly. Hold requests are kept low long enough to pass the synchronizer.

// File: rtl/bhr_pkg.sv
package bhr_pkg;
  typedef enum logic [1:0] {
    HS_RUN     = 2'd0,
    HS_ACKED   = 2'd1,
    HS_HELD    = 2'd2,
    HS_RELEASE = 2'd3
  } hold_state_e;
endpackage

// File: rtl/bhr_sync.sv
module bhr_sync #(
  parameter int STAGES = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[s] <= RESET_VAL;
      else if (s == 0) chain_q[s] <= d_i;
      else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/bhr_phase.sv
module bhr_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_i,
  input  logic rdy_n_i,
  output logic phi_o,
  output logic phi_fall_o,
  output logic free_clk_o
);
  logic phi_q, free_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phi_q  <= 1'b0;
      free_q <= 1'b0;
    end else if (ce_i) begin
      free_q <= ~free_q;
      // stall only in the low phase
      if (phi_q || rdy_n_i) phi_q <= ~phi_q;
    end
  end

  assign phi_o      = phi_q;
  assign phi_fall_o = ce_i & phi_q;
  assign free_clk_o = free_q;
endmodule

// File: rtl/bhr_hold_fsm.sv
module bhr_hold_fsm
  import bhr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic phi_fall_i,
  input  logic req_i,
  input  logic busy_i,
  output logic hlda_n_o,
  output logic bus_oe_o,
  output logic bus_go_o
);
  hold_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (phi_fall_i) begin
      unique case (st_q)
        HS_RUN:     if (req_i && !busy_i) st_d = HS_ACKED;
        HS_ACKED:   st_d = HS_HELD;
        HS_HELD:    if (!req_i) st_d = HS_RELEASE;
        HS_RELEASE: st_d = HS_RUN;
        default:    st_d = HS_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= HS_RUN;
    else st_q <= st_d;
  end

  assign hlda_n_o = !(st_q == HS_ACKED || st_q == HS_HELD);
  assign bus_oe_o = (st_q == HS_RUN) || (st_q == HS_ACKED);
  assign bus_go_o = (st_q == HS_RUN);
endmodule

// File: rtl/bhr_clkpin.sv
module bhr_clkpin (
  input  logic free_clk_i,
  input  logic out_dis_i,
  input  logic port_dir_i,
  input  logic port_latch_i,
  output logic pin_o,
  output logic pin_oe_o
);
  always_comb begin
    if (out_dis_i) begin
      pin_o    = port_latch_i;
      pin_oe_o = port_dir_i;
    end else begin
      pin_o    = free_clk_i;
      pin_oe_o = 1'b1;
    end
  end
endmodule

// File: rtl/bus_hold_ready_ctrl.sv
module bus_hold_ready_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_i,
  input  logic rdy_n_i,
  input  logic hold_req_n_i,
  input  logic bus_busy_i,
  input  logic out_dis_i,
  input  logic port_dir_i,
  input  logic port_latch_i,
  output logic phi_o,
  output logic hlda_n_o,
  output logic bus_oe_o,
  output logic bus_go_o,
  output logic clkpin_o,
  output logic clkpin_oe_o
);
  logic req_n_s, phi_fall, free_clk;

  bhr_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(hold_req_n_i), .q_o(req_n_s)
  );

  bhr_phase u_phase (
    .clk(clk), .rst_n(rst_n), .ce_i(ce_i), .rdy_n_i(rdy_n_i),
    .phi_o(phi_o), .phi_fall_o(phi_fall), .free_clk_o(free_clk)
  );

  bhr_hold_fsm u_hold (
    .clk(clk), .rst_n(rst_n), .phi_fall_i(phi_fall), .req_i(!req_n_s),
    .busy_i(bus_busy_i), .hlda_n_o(hlda_n_o), .bus_oe_o(bus_oe_o),
    .bus_go_o(bus_go_o)
  );

  bhr_clkpin u_pin (
    .free_clk_i(free_clk), .out_dis_i(out_dis_i), .port_dir_i(port_dir_i),
    .port_latch_i(port_latch_i), .pin_o(clkpin_o), .pin_oe_o(clkpin_oe_o)
  );
endmodule

// File: rtl/bhr_checker.sv
module bhr_checker (
  input logic clk,
  input logic rst_n,
  input logic ce_i,
  input logic rdy_n_i,
  input logic bus_busy_i,
  input logic out_dis_i,
  input logic phi_o,
  input logic hlda_n_o,
  input logic bus_oe_o,
  input logic bus_go_o,
  input logic clkpin_oe_o
);
  a_r2_phase_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_i |=> $stable(phi_o));
  a_r3_ready_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdy_n_i && !phi_o) |=> !phi_o);
  a_r5_pin_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    !out_dis_i |-> clkpin_oe_o);
  a_r6_ack_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hlda_n_o) |-> ($past(phi_o) && !phi_o));
  a_r7_ack_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hlda_n_o) |-> !$past(bus_busy_i));
  a_r8_float_lags: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hlda_n_o) |-> bus_oe_o);
  a_r9_drive_lags: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hlda_n_o) |-> !bus_oe_o);
  a_r10_go_safe: assert property (@(posedge clk) disable iff (!rst_n)
    bus_go_o |-> (hlda_n_o && bus_oe_o));
endmodule

bind bus_hold_ready_ctrl bhr_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ce_i(ce_i), .rdy_n_i(rdy_n_i),
  .bus_busy_i(bus_busy_i), .out_dis_i(out_dis_i), .phi_o(phi_o),
  .hlda_n_o(hlda_n_o), .bus_oe_o(bus_oe_o), .bus_go_o(bus_go_o),
  .clkpin_oe_o(clkpin_oe_o)
);

// File: tb/sim_bus_hold_ready_ctrl.sv
`timescale 1ns/1ps
module sim_bus_hold_ready_ctrl;
  logic clk = 1'b0, rst_n = 1'b0, ce = 1'b1, rdy_n = 1'b1, hreq_n = 1'b1;
  logic busy = 1'b0, dis = 1'b0, dir = 1'b0, latch = 1'b0;
  logic phi, hlda_n, oe, go, pin, pin_oe;
  logic ce_div = 1'b0;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  bus_hold_ready_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .ce_i(ce), .rdy_n_i(rdy_n), .hold_req_n_i(hreq_n),
    .bus_busy_i(busy), .out_dis_i(dis), .port_dir_i(dir), .port_latch_i(latch),
    .phi_o(phi), .hlda_n_o(hlda_n), .bus_oe_o(oe), .bus_go_o(go),
    .clkpin_o(pin), .clkpin_oe_o(pin_oe)
  );

  // {dis, dir, latch, expected oe, compare value}
  localparam logic [4:0] PIN_VEC [6] = '{
    5'b000_1_0, 5'b010_1_0, 5'b100_0_1, 5'b101_0_1, 5'b110_1_1, 5'b111_1_1
  };

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    if (ce_div) ce = ~ce;
  endtask

  task automatic wait_hlda(input logic lvl, output logic prev_phi, output bit ok);
    ok = 0;
    prev_phi = phi;
    for (int i = 0; i < 40 && !ok; i++) begin
      prev_phi = phi;
      tick();
      if (hlda_n == lvl) ok = 1;
    end
  endtask

  task automatic hold_cycle(input int lag, input string tag);
    logic pp;
    bit ok;
    hreq_n = 1'b0;
    wait_hlda(1'b0, pp, ok);
    chk({tag, " R6 ack seen"}, ok, 1'b1);
    chk("R6 ack on falling phase", pp & ~phi, 1'b1);
    chk("R8 pads still driven at ack", oe, 1'b1);
    chk("R10 go low in hold", go, 1'b0);
    for (int i = 1; i < lag; i++) tick();
    chk({tag, " R8 pads driven before lag"}, oe, 1'b1);
    tick();
    chk({tag, " R8 pads float after lag"}, oe, 1'b0);
    hreq_n = 1'b1;
    wait_hlda(1'b1, pp, ok);
    chk({tag, " R9 release seen"}, ok, 1'b1);
    chk("R9 release on falling phase", pp & ~phi, 1'b1);
    chk("R9 pads still float", oe, 1'b0);
    chk("R10 go waits for pads", go, 1'b0);
    for (int i = 1; i < lag; i++) tick();
    chk({tag, " R9 pads float before lag"}, oe, 1'b0);
    tick();
    chk({tag, " R9 pads driven"}, oe, 1'b1);
    chk("R10 go restored", go, 1'b1);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic p0, f0;
    logic pp;
    bit ok;
    bit stay;
    @(negedge clk); @(negedge clk);
    chk("R1 hlda_n reset", hlda_n, 1'b1);
    chk("R1 oe reset", oe, 1'b1);
    chk("R1 go reset", go, 1'b1);
    chk("R1 phi reset", phi, 1'b0);
    rst_n = 1'b1;

    // clock pin vector table (R5, R4)
    foreach (PIN_VEC[k]) begin
      {dis, dir, latch} = PIN_VEC[k][4:2];
      tick();
      chk($sformatf("R5 vec%0d oe", k), pin_oe, PIN_VEC[k][1]);
      if (PIN_VEC[k][0]) chk($sformatf("R5 vec%0d value", k), pin, latch);
    end
    dis = 1'b0;

    // R2 phase toggles, holds with ce low
    tick(); p0 = phi; tick();
    chk("R2 phi toggles", phi, ~p0);
    ce = 1'b0; p0 = phi; tick(); tick();
    chk("R2 phi holds without ce", phi, p0);
    ce = 1'b1;

    // R3 freeze, R4 free clock keeps running
    while (phi) tick();
    rdy_n = 1'b0;
    stay = 1;
    for (int i = 0; i < 4; i++) begin
      f0 = pin; tick();
      if (phi !== 1'b0) stay = 0;
      chk("R4 free clock runs during stall", pin, ~f0);
    end
    chk("R3 phi frozen low", stay, 1'b1);
    rdy_n = 1'b1; tick();
    chk("R3 phi resumes", phi, 1'b1);

    hold_cycle(2, "ce1");

    // R7 busy blocks acknowledge
    busy = 1'b1; hreq_n = 1'b0;
    stay = 1;
    for (int i = 0; i < 12; i++) begin tick(); if (hlda_n !== 1'b1) stay = 0; end
    chk("R7 no ack while busy", stay, 1'b1);
    busy = 1'b0;
    wait_hlda(1'b0, pp, ok);
    chk("R7 ack after busy clears", ok, 1'b1);
    hreq_n = 1'b1;
    wait_hlda(1'b1, pp, ok);
    for (int i = 0; i < 4; i++) tick();
    chk("R9 drives after busy test", oe, 1'b1);

    // divided enable: internal cycle is four clocks
    ce_div = 1'b1;
    hold_cycle(4, "cediv");
    ce_div = 1'b0; ce = 1'b1;

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule